// File: doc/BRIEF.md
# Ramped actuator drive sequencer

This block is the control state machine behind a piezo actuator period generator. It does not shape any waveform. For every output period it chooses the gate profile, the direction, and whether gate B is blanked or both outputs stay off. The period generator reports the end of each period, and the sequencer answers with a start pulse for the next period until the operation is over.

Two kinds of operation exist. A rising edge on the enable bit can start a power-up homing routine, in which the actuator is driven forward, rests, and then backs off in the opposite direction. A drive command moves the actuator by a pulse count. It can open with a blanked lead-in period and a rise ramp through five gate-B profiles. The steady run follows, and a fall ramp can close it. Commands that arrive while a drive is still in its lead-in, ramp or steady phase extend the steady run. Clearing the enable bit abandons any operation at once.

Top module: `piezo_ramp_seq`

## Requirements
- R1: With enable high and the block idle, a command with a nonzero count raises busy and pulses period_start in the next cycle. If rise_total is 0, the first period uses prof_sel 0 (normal profile) with suppress_b low.
- R2: If rise_total is nonzero, a drive starts with exactly one period that has suppress_b high and prof_sel 0.
- R3: Ramp period i (counting from 0 after the lead-in) of rise_total periods has prof_sel = 1 + the number of switching points rise_pts[k] (k=0..3, rise_pts[0] first) that are <= i. With ordered points this gives profile 1 for [0,P0), 2 for [P0,P1), 3 for [P1,P2), 4 for [P2,P3) and 5 for [P3,rise_total). Equal points skip a profile.
- R4: The steady phase lasts (step_cfg+1) x accepted pulses periods, all with prof_sel 0.
- R5: The fall ramp lasts fall_total periods. Period i has prof_sel = 5 - (the number of fall_pts[k] <= i), so the profiles run from 5 down to 1. With fall_total 0, busy drops right after the steady phase.
- R6: A 0-to-1 change of enable with init_skip 0 starts a routine of three parts. First come (step_cfg+1) x 16 x (mov_cfg+1) periods in direction dir_sel. Then 4 x (step_cfg+1) periods follow with quiet high. Last come (step_cfg+1) x n periods in the opposite direction, where ret_cfg 0,1,2,3 gives n = 2,1,3,4. All of these periods use prof_sel 0.
- R7: Busy stays high from the first period through the last, including the quiet ones. After every period_end, either period_start pulses in the next cycle or, after the final period, busy is low in that cycle. Busy is low after reset.
- R8: If enable is low at a clock edge, busy and period_start are low after that edge. No command starts an operation while enable is low.
- R9: A command that arrives during the lead-in, rise or steady phase adds its pulses to the steady run, even in the cycle of the final steady period_end. Commands that arrive during homing or the fall ramp are dropped.
- R10: The pulses accepted for one drive never exceed 512. Any excess in a command is discarded.
- R11: drive_dir 0 means the infinity direction and 1 means the macro direction. The direction is latched when an operation starts and is held for the whole drive, whatever dir_sel does later.
- R12: A 0-to-1 change of enable with init_skip 1 leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enable bit; low aborts and holds idle |
| init_skip | input | 1 | 1 skips the homing routine on enable rise |
| dir_sel | input | 1 | Direction for new operations (0 infinity, 1 macro) |
| step_cfg | input | 8 | Periods per pulse minus one |
| mov_cfg | input | 4 | Homing drive length code (16 x (code+1) pulses) |
| ret_cfg | input | 2 | Homing back-off code |
| rise_total | input | 6 | Rise ramp length in periods |
| rise_pts | input | 4x6 | Rise switching points, element 0 first |
| fall_total | input | 6 | Fall ramp length in periods |
| fall_pts | input | 4x6 | Fall switching points, element 0 first |
| cmd_strobe | input | 1 | Drive command valid for one cycle |
| cmd_count | input | 7 | Pulse count of the command |
| period_end | input | 1 | Period generator finished the current period |
| prof_sel | output | 3 | 0 normal, 1..5 ramp gate-B profile |
| drive_dir | output | 1 | Direction of the current period |
| suppress_b | output | 1 | Gate B blanked for this period |
| quiet | output | 1 | Both outputs off for this period |
| period_start | output | 1 | One-cycle pulse: begin a period with the outputs above |
| busy | output | 1 | Operation in progress |

## Verification
Two events can land on the same clock edge. A command can arrive together with the period_end that would close the steady run, and the enable bit can drop while a period is being completed. The bench raises the strobe in the cycle it pulses period_end on the last steady period and expects the run to continue by the added pulses and then move on to the fall ramp. In the enable case it expects busy to be low one cycle later with no further start pulse. Separate runs place commands inside the rise ramp, the fall ramp and the homing routine, and repeated commands push the total past the pulse cap. Each run's full period sequence is compared with one computed from segment boundaries.

// File: rtl/piezo_ramp_pkg.sv
package piezo_ramp_pkg;
  localparam int STEP_W     = 8;
  localparam int CMD_W      = 7;
  localparam int RAMP_W     = 6;
  localparam int MOV_W      = 4;
  localparam int RET_W      = 2;
  localparam int PROF_W     = 3;
  localparam int MOV_UNIT   = 16;
  localparam int WAIT_MULT  = 4;
  localparam int MAX_PULSES = 512;
  localparam int ACC_W      = $clog2(MAX_PULSES + 1);
  localparam int CNT_W      = $clog2(MAX_PULSES * (2 ** STEP_W) + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_HOME_FWD, PH_HOME_REST, PH_HOME_BACK,
    PH_LEAD, PH_RISE, PH_STEADY, PH_FALL
  } phase_t;

  // periods per pulse
  function automatic logic [CNT_W-1:0] step_len(input logic [STEP_W-1:0] s);
    return CNT_W'(s) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] ret_count(input logic [RET_W-1:0] r);
    case (r)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(1);
      2'd2:    return CNT_W'(3);
      default: return CNT_W'(4);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] home_fwd_len(input logic [STEP_W-1:0] s,
                                                    input logic [MOV_W-1:0] m);
    return step_len(s) * ((CNT_W'(m) + CNT_W'(1)) * CNT_W'(MOV_UNIT));
  endfunction

  function automatic logic [CNT_W-1:0] home_rest_len(input logic [STEP_W-1:0] s);
    return step_len(s) * CNT_W'(WAIT_MULT);
  endfunction

  function automatic logic [CNT_W-1:0] home_back_len(input logic [STEP_W-1:0] s,
                                                     input logic [RET_W-1:0] r);
    return step_len(s) * ret_count(r);
  endfunction

  function automatic logic [CNT_W-1:0] burst_len(input logic [STEP_W-1:0] s,
                                                 input logic [ACC_W-1:0] g);
    return step_len(s) * CNT_W'(g);
  endfunction
endpackage

// File: rtl/ramp_stage_map.sv
module ramp_stage_map
  import piezo_ramp_pkg::*;
#(
  parameter int PTS = 4
) (
  input  logic [RAMP_W-1:0]          idx,
  input  logic [PTS-1:0][RAMP_W-1:0] pts,
  input  logic                       falling,
  output logic [PROF_W-1:0]          prof
);
  logic [PTS-1:0]    passed;
  logic [PROF_W-1:0] n_passed;

  for (genvar k = 0; k < PTS; k++) begin : g_cmp
    assign passed[k] = (pts[k] <= idx);
  end

  always_comb begin
    n_passed = '0;
    for (int k = 0; k < PTS; k++) n_passed = n_passed + PROF_W'(passed[k]);
    prof = falling ? (PROF_W'(PTS + 1) - n_passed) : (n_passed + PROF_W'(1));
  end
endmodule

// File: rtl/pulse_grant.sv
module pulse_grant
  import piezo_ramp_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic [CMD_W-1:0] req,
  output logic [ACC_W-1:0] grant
);
  logic [ACC_W-1:0] room;
  logic [ACC_W-1:0] req_w;

  always_comb begin
    room  = ACC_W'(MAX_PULSES) - acc;
    req_w = ACC_W'(req);
    grant = (req_w > room) ? room : req_w;
  end
endmodule

// File: rtl/piezo_ramp_seq.sv
module piezo_ramp_seq
  import piezo_ramp_pkg::*;
#(
  parameter int RAMP_PTS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable,
  input  logic                            init_skip,
  input  logic                            dir_sel,
  input  logic [STEP_W-1:0]               step_cfg,
  input  logic [MOV_W-1:0]                mov_cfg,
  input  logic [RET_W-1:0]                ret_cfg,
  input  logic [RAMP_W-1:0]               rise_total,
  input  logic [RAMP_PTS-1:0][RAMP_W-1:0] rise_pts,
  input  logic [RAMP_W-1:0]               fall_total,
  input  logic [RAMP_PTS-1:0][RAMP_W-1:0] fall_pts,
  input  logic                            cmd_strobe,
  input  logic [CMD_W-1:0]                cmd_count,
  input  logic                            period_end,
  output logic [PROF_W-1:0]               prof_sel,
  output logic                            drive_dir,
  output logic                            suppress_b,
  output logic                            quiet,
  output logic                            period_start,
  output logic                            busy
);
  phase_t                          phase, adv_phase;
  logic [CNT_W-1:0]                ph_left, adv_len, steady_bank, bank_next;
  logic [CNT_W-1:0]                add_len, steady_left_nx;
  logic [ACC_W-1:0]                pulse_acc, acc_base, grant;
  logic                            en_q, op_dir;
  // named internal events
  logic                            en_rise, home_go, can_merge, cmd_ok, new_op, merge;
  logic                            in_ramp, falling, period_last;
  logic [RAMP_W-1:0]               ramp_total, ramp_idx;
  logic [RAMP_PTS-1:0][RAMP_W-1:0] ramp_pts;
  logic [PROF_W-1:0]               map_prof;

  assign en_rise   = enable & ~en_q;
  assign home_go   = en_rise & ~init_skip;
  assign can_merge = (phase == PH_LEAD) | (phase == PH_RISE) | (phase == PH_STEADY);
  assign cmd_ok    = enable & cmd_strobe & (cmd_count != '0) & ~home_go
                   & ((phase == PH_IDLE) | can_merge);
  assign new_op    = cmd_ok & (phase == PH_IDLE);
  assign merge     = cmd_ok & can_merge;
  assign acc_base  = (phase == PH_IDLE) ? '0 : pulse_acc;

  pulse_grant u_grant (
    .acc  (acc_base),
    .req  (cmd_count),
    .grant(grant)
  );

  assign add_len        = burst_len(step_cfg, grant);
  assign bank_next      = steady_bank + (merge ? add_len : '0);
  assign steady_left_nx = ph_left - CNT_W'(period_end) + (merge ? add_len : '0);
  assign period_last    = (phase == PH_STEADY) ? (steady_left_nx == '0)
                                               : (period_end && ph_left == CNT_W'(1));

  // ramp profile lookup
  assign falling    = (phase == PH_FALL);
  assign in_ramp    = (phase == PH_RISE) | falling;
  assign ramp_total = falling ? fall_total : rise_total;
  assign ramp_pts   = falling ? fall_pts : rise_pts;
  assign ramp_idx   = ramp_total - ph_left[RAMP_W-1:0];

  ramp_stage_map #(.PTS(RAMP_PTS)) u_map (
    .idx    (ramp_idx),
    .pts    (ramp_pts),
    .falling(falling),
    .prof   (map_prof)
  );

  // phase that follows the current one
  always_comb begin
    adv_phase = PH_IDLE;
    adv_len   = '0;
    case (phase)
      PH_HOME_FWD:  begin adv_phase = PH_HOME_REST; adv_len = home_rest_len(step_cfg); end
      PH_HOME_REST: begin adv_phase = PH_HOME_BACK; adv_len = home_back_len(step_cfg, ret_cfg); end
      PH_LEAD:      begin adv_phase = PH_RISE;      adv_len = CNT_W'(rise_total); end
      PH_RISE:      begin adv_phase = PH_STEADY;    adv_len = bank_next; end
      PH_STEADY: begin
        if (fall_total != '0) begin
          adv_phase = PH_FALL;
          adv_len   = CNT_W'(fall_total);
        end
      end
      default: begin adv_phase = PH_IDLE; adv_len = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      ph_left      <= '0;
      steady_bank  <= '0;
      pulse_acc    <= '0;
      en_q         <= 1'b0;
      op_dir       <= 1'b0;
      period_start <= 1'b0;
    end else begin
      en_q         <= enable;
      period_start <= 1'b0;
      if (!enable) begin
        phase   <= PH_IDLE;
        ph_left <= '0;
      end else if (home_go) begin
        phase        <= PH_HOME_FWD;
        ph_left      <= home_fwd_len(step_cfg, mov_cfg);
        op_dir       <= dir_sel;
        period_start <= 1'b1;
      end else if (new_op) begin
        op_dir       <= dir_sel;
        pulse_acc    <= grant;
        steady_bank  <= add_len;
        period_start <= 1'b1;
        if (rise_total != '0) begin
          phase   <= PH_LEAD;
          ph_left <= CNT_W'(1);
        end else begin
          phase   <= PH_STEADY;
          ph_left <= add_len;
        end
      end else if (phase != PH_IDLE) begin
        if (merge) begin
          pulse_acc   <= pulse_acc + grant;
          steady_bank <= bank_next;
        end
        if (period_last) begin
          phase        <= adv_phase;
          ph_left      <= adv_len;
          period_start <= (adv_phase != PH_IDLE);
          if (adv_phase == PH_HOME_BACK) op_dir <= ~op_dir;
        end else if (phase == PH_STEADY) begin
          ph_left      <= steady_left_nx;
          period_start <= period_end;
        end else if (period_end) begin
          ph_left      <= ph_left - CNT_W'(1);
          period_start <= 1'b1;
        end
      end
    end
  end

  assign prof_sel   = in_ramp ? map_prof : '0;
  assign suppress_b = (phase == PH_LEAD);
  assign quiet      = (phase == PH_HOME_REST);
  assign drive_dir  = op_dir;
  assign busy       = (phase != PH_IDLE);
endmodule

// File: rtl/piezo_ramp_seq_chk.sv
module piezo_ramp_seq_chk
  import piezo_ramp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              period_end,
  input logic [PROF_W-1:0] prof_sel,
  input logic              drive_dir,
  input logic              suppress_b,
  input logic              quiet,
  input logic              period_start,
  input logic              busy
);
  p_enable_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !period_start));

  p_start_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> busy);

  p_first_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> period_start);

  p_start_follows_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && $past(busy)) |-> $past(period_end));

  p_lead_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_b |-> (prof_sel == '0 && !quiet));

  p_rest_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (prof_sel == '0 && busy));

  p_prof_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prof_sel <= PROF_W'(5));

  p_dir_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !period_start) |-> $stable(drive_dir));
endmodule

bind piezo_ramp_seq piezo_ramp_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .period_end  (period_end),
  .prof_sel    (prof_sel),
  .drive_dir   (drive_dir),
  .suppress_b  (suppress_b),
  .quiet       (quiet),
  .period_start(period_start),
  .busy        (busy)
);

// File: tb/piezo_ramp_seq_tb.sv
module piezo_ramp_seq_tb;
  import piezo_ramp_pkg::*;

  localparam int LIM = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0, enable = 1'b1, init_skip = 1'b1, dir_sel = 1'b0;
  logic [7:0]       step_cfg = '0;
  logic [3:0]       mov_cfg = '0;
  logic [1:0]       ret_cfg = '0;
  logic [5:0]       rise_total = '0, fall_total = '0;
  logic [3:0][5:0]  rise_pts = '0, fall_pts = '0;
  logic             cmd_strobe = 1'b0, period_end = 1'b0;
  logic [6:0]       cmd_count = '0;
  logic [2:0]       prof_sel;
  logic             drive_dir, suppress_b, quiet, period_start, busy;

  piezo_ramp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .init_skip(init_skip), .dir_sel(dir_sel),
    .step_cfg(step_cfg), .mov_cfg(mov_cfg), .ret_cfg(ret_cfg),
    .rise_total(rise_total), .rise_pts(rise_pts), .fall_total(fall_total), .fall_pts(fall_pts),
    .cmd_strobe(cmd_strobe), .cmd_count(cmd_count), .period_end(period_end),
    .prof_sel(prof_sel), .drive_dir(drive_dir), .suppress_b(suppress_b), .quiet(quiet),
    .period_start(period_start), .busy(busy)
  );

  int checks = 0, fails = 0;
  int got_n, exp_n, late_n;
  int g_prof [LIM], e_prof [LIM];
  bit g_dir [LIM], e_dir [LIM], g_sup [LIM], e_sup [LIM], g_q [LIM], e_q [LIM];

  int              rt_tab [4] = '{0, 5, 7, 4};
  logic [3:0][5:0] rp_tab [4] = '{24'd0, {6'd4, 6'd3, 6'd2, 6'd1},
                                  {6'd6, 6'd4, 6'd2, 6'd2}, {6'd4, 6'd0, 6'd0, 6'd0}};
  int              ft_tab [3] = '{0, 5, 6};
  logic [3:0][5:0] fp_tab [3] = '{24'd0, {6'd4, 6'd3, 6'd2, 6'd1}, {6'd6, 6'd3, 6'd3, 6'd0}};

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", msg, act, expv);
    end
  endtask

  task automatic push(input int prof, input bit dir, input bit sup, input bit q, input int cnt);
    for (int i = 0; i < cnt; i++)
      if (exp_n < LIM) begin
        e_prof[exp_n] = prof; e_dir[exp_n] = dir; e_sup[exp_n] = sup; e_q[exp_n] = q;
        exp_n++;
      end
  endtask

  // expected drive: lead-in, ramp segments between boundaries, steady, falling segments
  task automatic build_drive(input int pulses, input int step, input bit dir,
                             input int rt, input logic [3:0][5:0] rp,
                             input int ft, input logic [3:0][5:0] fp);
    int b [6];
    exp_n = 0;
    if (rt != 0) begin
      push(0, dir, 1'b1, 1'b0, 1);
      b[0] = 0; b[5] = rt;
      for (int j = 0; j < 4; j++) b[j+1] = int'(rp[j]);
      for (int k = 1; k <= 5; k++) push(k, dir, 1'b0, 1'b0, b[k] - b[k-1]);
    end
    push(0, dir, 1'b0, 1'b0, (step + 1) * pulses);
    if (ft != 0) begin
      b[0] = 0; b[5] = ft;
      for (int j = 0; j < 4; j++) b[j+1] = int'(fp[j]);
      for (int k = 1; k <= 5; k++) push(6 - k, dir, 1'b0, 1'b0, b[k] - b[k-1]);
    end
  endtask

  task automatic build_home(input int step, input int mov, input int ret, input bit dir);
    int back;
    back = (ret == 0) ? 2 : (ret == 1) ? 1 : ret + 1;
    exp_n = 0;
    push(0, dir, 1'b0, 1'b0, (step + 1) * 16 * (mov + 1));
    push(0, dir, 1'b0, 1'b1, 4 * (step + 1));
    push(0, !dir, 1'b0, 1'b0, (step + 1) * back);
  endtask

  task automatic start_cmd(input int c);
    cmd_count = 7'(c); cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  // acts as the period generator; mode 1 strobes at a period start, mode 2 with its period_end
  task automatic collect(input int gap, input int inj_from, input int inj_reps,
                         input int inj_cnt, input int inj_mode);
    int guard;
    bit inj;
    guard = 0; got_n = 0; late_n = 0;
    while (busy && guard < 20000) begin
      if (period_start) begin
        inj = (got_n >= inj_from) && (got_n < inj_from + inj_reps);
        if (got_n < LIM) begin
          g_prof[got_n] = int'(prof_sel); g_dir[got_n] = drive_dir;
          g_sup[got_n] = suppress_b; g_q[got_n] = quiet;
        end
        got_n++;
        if (inj && inj_mode == 1) begin cmd_count = 7'(inj_cnt); cmd_strobe = 1'b1; end
        @(negedge clk);
        cmd_strobe = 1'b0;
        repeat (gap) @(negedge clk);
        period_end = 1'b1;
        if (inj && inj_mode == 2) begin cmd_count = 7'(inj_cnt); cmd_strobe = 1'b1; end
        @(negedge clk);
        period_end = 1'b0; cmd_strobe = 1'b0;
        if (busy && !period_start) late_n++;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    checks++;
    if (got_n == exp_n)
      for (int i = 0; i < got_n && i < LIM; i++)
        if (bad < 0 && (g_prof[i] != e_prof[i] || g_dir[i] != e_dir[i] ||
                        g_sup[i] != e_sup[i] || g_q[i] != e_q[i])) bad = i;
    if (got_n != exp_n) begin
      fails++;
      $display("FAIL %s: %0d periods, expected %0d", tag, got_n, exp_n);
    end else if (bad >= 0) begin
      fails++;
      $display("FAIL %s: period %0d prof/dir/supB/quiet = %0d/%0d/%0d/%0d, expected %0d/%0d/%0d/%0d",
               tag, bad, g_prof[bad], g_dir[bad], g_sup[bad], g_q[bad],
               e_prof[bad], e_dir[bad], e_sup[bad], e_q[bad]);
    end else if (late_n != 0) begin
      fails++;
      $display("FAIL %s R7: %0d period_end pulses not followed by start or end, expected 0",
               tag, late_n);
    end
  endtask

  task automatic set_cfg(input int r, input int f, input int s, input bit d);
    rise_total = 6'(rt_tab[r]); rise_pts = rp_tab[r];
    fall_total = 6'(ft_tab[f]); fall_pts = fp_tab[f];
    step_cfg = 8'(s); dir_sel = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R7 watchdog: run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !period_start, "R7 reset state busy/start", int'(busy), 0);
    // enable rose at reset release with init_skip high
    seen = 0;
    repeat (6) begin @(negedge clk); if (busy || period_start) seen++; end
    check(seen == 0, "R12 enable rise with init skipped stays idle", seen, 0);

    // drive sweep
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 3; f++)
        for (int s = 0; s < 3; s += 2)
          for (int c = 1; c < 4; c += 2)
            for (int d = 0; d < 2; d++) begin
              @(negedge clk);
              set_cfg(r, f, s, d[0]);
              build_drive(c, s, d[0], rt_tab[r], rp_tab[r], ft_tab[f], fp_tab[f]);
              start_cmd(c);
              dir_sel = ~d[0];  // R11: later changes must not matter
              collect(1 + (c % 2), 0, 0, 0, 0);
              compare("R1/R2/R3/R4/R5/R7/R11 drive sweep");
            end

    // homing sweep
    init_skip = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int rt = 0; rt < 4; rt++)
          for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            enable = 1'b0; step_cfg = 8'(s); mov_cfg = 4'(m); ret_cfg = 2'(rt); dir_sel = d[0];
            @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            build_home(s, m, rt, d[0]);
            collect(1, 0, 0, 0, 0);
            compare("R6/R7 homing sweep");
          end

    // R9: command during homing is dropped
    @(negedge clk);
    enable = 1'b0; step_cfg = 8'd0; mov_cfg = 4'd0; ret_cfg = 2'd1; dir_sel = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    build_home(0, 0, 1, 1'b0);
    collect(1, 5, 1, 4, 1);
    compare("R9 command during homing ignored");
    init_skip = 1'b1;

    // R9: command during rise adds to steady
    @(negedge clk);
    set_cfg(1, 0, 1, 1'b1);
    build_drive(5, 1, 1'b1, rt_tab[1], rp_tab[1], 0, 24'd0);
    start_cmd(2);
    collect(1, 2, 1, 3, 1);
    compare("R9 command during rise ramp merged");

    // R9: command in the same cycle as the last steady period_end
    @(negedge clk);
    set_cfg(0, 1, 0, 1'b0);
    build_drive(4, 0, 1'b0, 0, 24'd0, ft_tab[1], fp_tab[1]);
    start_cmd(2);
    collect(1, 1, 1, 2, 2);
    compare("R9 command with final steady period_end");

    // R9: command during fall ramp dropped
    @(negedge clk);
    set_cfg(0, 1, 0, 1'b1);
    build_drive(2, 0, 1'b1, 0, 24'd0, ft_tab[1], fp_tab[1]);
    start_cmd(2);
    collect(1, 3, 1, 5, 1);
    compare("R9 command during fall ramp ignored");

    // R10: pulse cap
    @(negedge clk);
    set_cfg(0, 0, 0, 1'b0);
    build_drive(512, 0, 1'b0, 0, 24'd0, 0, 24'd0);
    start_cmd(127);
    collect(1, 0, 5, 127, 1);
    compare("R10 accepted pulses capped at 512");

    // R8: enable drop mid-operation, together with a period_end
    @(negedge clk);
    set_cfg(1, 1, 2, 1'b0);
    start_cmd(3);
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R7 busy during drive", int'(busy), 1);
    enable = 1'b0; period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
    check(!busy && !period_start, "R8 busy after enable drop", int'(busy), 0);
    cmd_count = 7'd3; cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
    seen = 0;
    repeat (5) begin @(negedge clk); if (busy || period_start) seen++; end
    check(seen == 0, "R8 command with enable low ignored", seen, 0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy, "R12 re-enable with init skipped stays idle", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule